// File: doc/BRIEF.md
# Chip-Select Bank Decoder with Boot Remap

This block sits between the processor's physical address bus and the external memory pins. Each bus request carries a 32-bit physical address. The block sorts it into one of four targets:

- one of eight external memory banks, each 128 MB, which together cover the lowest 1 GB;
- a 4 KB on-chip boot SRAM;
- an internal register window;
- an unmapped hole.

For a bank hit, it drives that bank's active-low chip select and hands the low 27 address bits to the bank as the in-bank address.

A boot-mode strap changes what answers at address zero. With the strap low, the part boots from linear NOR flash: bank 0 is decoded like every other bank, so the flash answers at zero. With the strap high, the part boots from NAND. The on-chip SRAM then takes over the first 4 KB. Any other address in the bank 0 range is reported as unmapped, and chip select 0 is never driven.

The decode is combinational from the address, the request-valid input and the strap. Every output is registered and appears one clock after the request, together with a response-valid flag.

Top module: `cs_bank_decoder`

## Requirements
- R1: For a valid request with address below 0x4000_0000 whose bank is not bank 0 in NAND-boot mode, `bank_cs_n[addr[29:27]]` goes low and every other chip select stays high. Bank n therefore starts at n*0x0800_0000, so bank 6 starts at 0x3000_0000.
- R2: For every valid request, `bank_addr` equals bits [26:0] of the request address.
- R3: At most one chip select is ever low. While `rsp_valid` is high, exactly one of these holds: some chip select low, `sram_sel`, `reg_sel`, `unmapped`.
- R4: With `boot_nand`=0, addresses 0x0000_0000 to 0x07FF_FFFF drive `bank_cs_n[0]` low.
- R5: With `boot_nand`=1, addresses 0x0000_0000 to 0x0000_0FFF raise `sram_sel`, and all chip selects stay high.
- R6: With `boot_nand`=1, addresses 0x0000_1000 to 0x07FF_FFFF raise `unmapped`, with no chip select and no `sram_sel`.
- R7: Addresses 0x4800_0000 to 0x5FFF_FFFF raise `reg_sel`, with all chip selects high, in either boot mode.
- R8: Addresses 0x4000_0000 to 0x47FF_FFFF and 0x6000_0000 to 0xFFFF_FFFF raise `unmapped`, in either boot mode.
- R9: When `req_valid` was low, the address and strap inputs have no effect in the next cycle: all chip selects are high, `sram_sel`, `reg_sel` and `unmapped` are low, `bank_addr` is zero and `rsp_valid` is low.
- R10: Each output reflects the request of the previous clock cycle, and `rsp_valid` equals the previous cycle's `req_valid`.
- R11: While `rst_n` is low, all chip selects are high, `bank_addr` is zero, and `sram_sel`, `reg_sel`, `unmapped` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_nand | input | 1 | Boot strap: 1 = NAND boot (SRAM at zero), 0 = NOR boot |
| req_valid | input | 1 | A bus access is presented this cycle |
| req_addr | input | 32 | Physical address of the access |
| rsp_valid | output | 1 | Registered outputs describe a request |
| bank_cs_n | output | 8 | Active-low chip selects, one per bank |
| bank_addr | output | 27 | In-bank address |
| sram_sel | output | 1 | Access targets the on-chip boot SRAM |
| reg_sel | output | 1 | Access targets the internal register window |
| unmapped | output | 1 | Access falls in no mapped target |

## Verification
The first pattern is the first and last byte of every bank in both strap settings. This tells a wrong bank-select bit slice apart from an off-by-one at a bank boundary. Probes just either side of 0x1000, 0x4000_0000, 0x4800_0000 and 0x6000_0000 separate the SRAM, register-window and hole comparisons. A pseudo-random sweep mixes idle cycles, which randomise the address while `req_valid` is low. It also flips the strap between back-to-back requests, which exposes any stale state or strap latching.

// File: rtl/cs_decode_pkg.sv
package cs_decode_pkg;

  localparam int ADDR_W     = 32;
  localparam int BANK_CNT   = 8;
  localparam int BANK_AW    = 27;
  localparam int SRAM_AW    = 12;
  localparam logic [ADDR_W-1:0] REG_FIRST = 32'h4800_0000;
  localparam logic [ADDR_W-1:0] REG_LAST  = 32'h5FFF_FFFF;

  localparam int BANK_SEL_W = $clog2(BANK_CNT);
  localparam int EXT_TOP    = BANK_AW + BANK_SEL_W;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_BANK,
    TGT_SRAM,
    TGT_REG,
    TGT_HOLE
  } tgt_e;

  typedef struct packed {
    tgt_e                  tgt;
    logic [BANK_SEL_W-1:0] bank;
    logic [BANK_AW-1:0]    offset;
  } decode_t;

  // Address lies inside the external banked region.
  function automatic logic f_is_external(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:EXT_TOP] == '0;
  endfunction

  // Bank number taken from the bits just above the in-bank address.
  function automatic logic [BANK_SEL_W-1:0] f_bank_of(input logic [ADDR_W-1:0] a);
    return a[EXT_TOP-1:BANK_AW];
  endfunction

  // Address lies inside the first SRAM-sized slice of bank 0.
  function automatic logic f_in_boot_sram(input logic [ADDR_W-1:0] a);
    return f_is_external(a) && (f_bank_of(a) == '0) && (a[BANK_AW-1:SRAM_AW] == '0);
  endfunction

  // Address lies inside the internal register window.
  function automatic logic f_in_reg_window(input logic [ADDR_W-1:0] a);
    return (a >= REG_FIRST) && (a <= REG_LAST);
  endfunction

endpackage

// File: rtl/addr_region_classifier.sv
module addr_region_classifier
  import cs_decode_pkg::*;
(
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              boot_nand,
  output decode_t           dec,
  output logic              ext_hit,
  output logic              sram_hit,
  output logic              reg_hit
);

  assign ext_hit  = f_is_external(req_addr);
  assign sram_hit = f_in_boot_sram(req_addr);
  assign reg_hit  = f_in_reg_window(req_addr);

  always_comb begin
    dec.tgt    = TGT_NONE;
    dec.bank   = '0;
    dec.offset = '0;
    if (req_valid) begin
      dec.offset = req_addr[BANK_AW-1:0];
      dec.bank   = f_bank_of(req_addr);
      if (ext_hit) begin
        if (boot_nand && (dec.bank == '0)) begin
          dec.tgt = sram_hit ? TGT_SRAM : TGT_HOLE;
        end else begin
          dec.tgt = TGT_BANK;
        end
      end else if (reg_hit) begin
        dec.tgt = TGT_REG;
      end else begin
        dec.tgt = TGT_HOLE;
      end
    end
  end

  // R3: the register window and the external region never overlap
  always_comb begin
    a_r3_regions_disjoint: assert (!(ext_hit && reg_hit))
      else $error("external and register regions overlap");
  end

endmodule

// File: rtl/bank_select_gen.sv
module bank_select_gen
  import cs_decode_pkg::*;
(
  input  tgt_e                  tgt,
  input  logic [BANK_SEL_W-1:0] bank,
  output logic [BANK_CNT-1:0]   cs_n_next
);

  for (genvar g = 0; g < BANK_CNT; g++) begin : g_cs
    assign cs_n_next[g] = !((tgt == TGT_BANK) && (bank == BANK_SEL_W'(g)));
  end

  // R3: at most one chip select requested per cycle
  always_comb begin
    a_r3_single_cs_next: assert ($countones(~cs_n_next) <= 1)
      else $error("more than one chip select requested");
  end

endmodule

// File: rtl/decode_out_reg.sv
module decode_out_reg
  import cs_decode_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  tgt_e                tgt,
  input  logic [BANK_AW-1:0]  offset,
  input  logic [BANK_CNT-1:0] cs_n_next,
  output logic                rsp_valid,
  output logic [BANK_CNT-1:0] bank_cs_n,
  output logic [BANK_AW-1:0]  bank_addr,
  output logic                sram_sel,
  output logic                reg_sel,
  output logic                unmapped
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      bank_cs_n <= '1;
      bank_addr <= '0;
      sram_sel  <= 1'b0;
      reg_sel   <= 1'b0;
      unmapped  <= 1'b0;
    end else begin
      rsp_valid <= (tgt != TGT_NONE);
      bank_cs_n <= cs_n_next;
      bank_addr <= offset;
      sram_sel  <= (tgt == TGT_SRAM);
      reg_sel   <= (tgt == TGT_REG);
      unmapped  <= (tgt == TGT_HOLE);
    end
  end

  // R9: no response means every output is quiet
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (&bank_cs_n && !sram_sel && !reg_sel && !unmapped && bank_addr == '0))
    else $error("outputs active without a response");

endmodule

// File: rtl/cs_bank_decoder.sv
module cs_bank_decoder
  import cs_decode_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                boot_nand,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_addr,
  output logic                rsp_valid,
  output logic [BANK_CNT-1:0] bank_cs_n,
  output logic [BANK_AW-1:0]  bank_addr,
  output logic                sram_sel,
  output logic                reg_sel,
  output logic                unmapped
);

  decode_t             dec;
  logic                ext_hit;
  logic                sram_hit;
  logic                reg_hit;
  logic [BANK_CNT-1:0] cs_n_next;

  addr_region_classifier u_classify (
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .boot_nand (boot_nand),
    .dec       (dec),
    .ext_hit   (ext_hit),
    .sram_hit  (sram_hit),
    .reg_hit   (reg_hit)
  );

  bank_select_gen u_cs_gen (
    .tgt       (dec.tgt),
    .bank      (dec.bank),
    .cs_n_next (cs_n_next)
  );

  decode_out_reg u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .tgt       (dec.tgt),
    .offset    (dec.offset),
    .cs_n_next (cs_n_next),
    .rsp_valid (rsp_valid),
    .bank_cs_n (bank_cs_n),
    .bank_addr (bank_addr),
    .sram_sel  (sram_sel),
    .reg_sel   (reg_sel),
    .unmapped  (unmapped)
  );

  logic any_cs;
  assign any_cs = ~&bank_cs_n;

  // R3: never two chip selects at the pins
  a_r3_onehot_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bank_cs_n))
    else $error("two chip selects low");

  // R3: one target per response
  a_r3_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({any_cs, sram_sel, reg_sel, unmapped}) == 1))
    else $error("response without exactly one target");

  // R10: response valid follows request valid by one cycle
  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid)
    else $error("request lost");

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid)
    else $error("response without request");

  // R2: in-bank address carried through
  a_r2_offset: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (bank_addr == $past(req_addr[BANK_AW-1:0])))
    else $error("in-bank address wrong");

  // R7: register window selects registers
  a_r7_reg_window: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && reg_hit) |=> (reg_sel && &bank_cs_n))
    else $error("register window missed");

  // R6: NAND boot, bank 0 outside the SRAM is a hole
  a_r6_nand_hole: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && boot_nand && ext_hit && dec.bank == '0 && !sram_hit) |=> (unmapped && &bank_cs_n))
    else $error("bank 0 hole not flagged");

endmodule

// File: tb/cs_bank_decoder_bench.sv
module cs_bank_decoder_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_nand = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic [7:0]  bank_cs_n;
  logic [26:0] bank_addr;
  logic        sram_sel;
  logic        reg_sel;
  logic        unmapped;

  always #5 clk = ~clk;

  cs_bank_decoder u_cs_bank_decoder (
    .clk(clk), .rst_n(rst_n), .boot_nand(boot_nand), .req_valid(req_valid),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .bank_cs_n(bank_cs_n),
    .bank_addr(bank_addr), .sram_sel(sram_sel), .reg_sel(reg_sel), .unmapped(unmapped)
  );

  typedef struct packed {
    logic        v;
    logic [7:0]  cs_n;
    logic [26:0] addr;
    logic        sram;
    logic        regw;
    logic        unm;
  } expect_t;

  expect_t     pending[$];
  string       tag_q[$];
  int          checks = 0;
  int          errors = 0;
  int          cycles = 0;
  logic [31:0] lcg = 32'h1234_5678;

  // Behavioural model: integer arithmetic on the address map
  function automatic expect_t model(input logic v, input logic [31:0] a, input logic nand_b,
                                    output string tag);
    expect_t e;
    longint unsigned la = a;
    longint unsigned bank;
    e = '{v:1'b0, cs_n:8'hFF, addr:'0, sram:1'b0, regw:1'b0, unm:1'b0};
    tag = "R9";
    if (!v) return e;
    e.v    = 1'b1;
    e.addr = 27'(la % 64'h0800_0000);
    if (la < 64'h4000_0000) begin
      bank = la / 64'h0800_0000;
      if (bank == 0 && nand_b) begin
        if (la < 4096) begin e.sram = 1'b1; tag = "R5"; end
        else begin e.unm = 1'b1; tag = "R6"; end
      end else begin
        e.cs_n = ~(8'd1 << bank);
        tag = (bank == 0) ? "R4" : "R1";
      end
    end else if (la >= 64'h4800_0000 && la < 64'h6000_0000) begin
      e.regw = 1'b1; tag = "R7";
    end else begin
      e.unm = 1'b1; tag = "R8";
    end
    return e;
  endfunction

  task automatic compare(input expect_t e, input string tag);
    checks++;
    if (rsp_valid !== e.v || bank_cs_n !== e.cs_n || bank_addr !== e.addr ||
        sram_sel !== e.sram || reg_sel !== e.regw || unmapped !== e.unm) begin
      errors++;
      $display("FAIL %s (R2/R3/R10 path): got v=%b cs_n=%h addr=%h sram=%b reg=%b unm=%b exp v=%b cs_n=%h addr=%h sram=%b reg=%b unm=%b",
               tag, rsp_valid, bank_cs_n, bank_addr, sram_sel, reg_sel, unmapped,
               e.v, e.cs_n, e.addr, e.sram, e.regw, e.unm);
    end
  endtask

  // One cycle: check last cycle's expectation, then drive and predict
  task automatic step(input logic v, input logic [31:0] a, input logic nand_b);
    string   t;
    expect_t e;
    @(negedge clk);
    if (pending.size() > 0) compare(pending.pop_front(), tag_q.pop_front());
    req_valid = v;
    req_addr  = a;
    boot_nand = nand_b;
    e = model(v, a, nand_b, t);
    pending.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got cycles=%0d expected <= 100000", cycles);
      summary();
    end
  end

  initial begin
    // R11: reset state with a live-looking request on the inputs
    req_valid = 1'b1;
    req_addr  = 32'h3000_0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || bank_cs_n !== 8'hFF || bank_addr !== '0 ||
        sram_sel !== 1'b0 || reg_sel !== 1'b0 || unmapped !== 1'b0) begin
      errors++;
      $display("FAIL R11: got v=%b cs_n=%h addr=%h exp v=0 cs_n=ff addr=0",
               rsp_valid, bank_cs_n, bank_addr);
    end
    req_valid = 1'b0;
    rst_n = 1'b1;
    pending.push_back('{v:1'b0, cs_n:8'hFF, addr:'0, sram:1'b0, regw:1'b0, unm:1'b0});
    tag_q.push_back("R9");

    // R1 R4 R2: first and last byte of each bank, both straps
    for (int m = 0; m < 2; m++) begin
      for (int b = 0; b < 8; b++) begin
        step(1'b1, 32'(b) * 32'h0800_0000, m[0]);
        step(1'b1, 32'(b) * 32'h0800_0000 + 32'h07FF_FFFF, m[0]);
      end
    end
    // R1: SDRAM bank start
    step(1'b1, 32'h3000_0000, 1'b0);
    // R5 R6: SRAM edge in NAND mode
    step(1'b1, 32'h0000_0000, 1'b1);
    step(1'b1, 32'h0000_0FFF, 1'b1);
    step(1'b1, 32'h0000_1000, 1'b1);
    step(1'b1, 32'h0000_0FFF, 1'b0);
    // R7 R8: window and hole edges, both straps
    for (int m = 0; m < 2; m++) begin
      step(1'b1, 32'h3FFF_FFFF, m[0]);
      step(1'b1, 32'h4000_0000, m[0]);
      step(1'b1, 32'h47FF_FFFF, m[0]);
      step(1'b1, 32'h4800_0000, m[0]);
      step(1'b1, 32'h5FFF_FFFF, m[0]);
      step(1'b1, 32'h6000_0000, m[0]);
      step(1'b1, 32'hFFFF_FFFF, m[0]);
    end
    // R9: idle with addresses that would select something
    step(1'b0, 32'h3000_0010, 1'b0);
    step(1'b0, 32'h4800_0000, 1'b1);
    step(1'b0, 32'h0000_0004, 1'b1);
    // R10 R3: random sweep, idle gaps and strap flips
    for (int i = 0; i < 3000; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      step(lcg[3:0] != 4'd0, {lcg[31:29], lcg[28:0] ^ {lcg[12:0], 16'h0}}, lcg[7]);
    end
    step(1'b0, 32'h0, 1'b0);
    step(1'b0, 32'h0, 1'b0);
    summary();
  end

endmodule